// File: doc/BRIEF.md
# Configuration Stream Payload Extractor

This block sits in the path of a device configuration file that arrives one byte at a time. It drops everything ahead of the payload and forwards only the payload to the next stage. The file opens with a fixed block of bytes, then four text records. Each record has a length byte in front of it. After the records comes a search for a synchronisation pattern that marks where the payload starts.

A mode input sets what the pattern looks like and whether its bytes belong to the payload. In raw mode the pattern is a run of four 0xFF bytes, and those four bytes are the first bytes sent out. In compressed mode the pattern is 0xFF followed by a byte in the range 0x30 to 0x3F. Both pattern bytes are removed, and output begins with the byte after them. Both sides use valid/ready byte streams, and each side has a last flag. A counter gives the number of payload bytes sent so far. A sticky error output goes high when the input ends before any pattern is found.

Top module: `bitstream_payload_locator`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0, payload_count is 0 and no_sync_err is 0.
- R2: The first 15 accepted bytes are dropped whatever their values (0xFF and 0x3x included), and byte 15 is read as the first record length.
- R3: There are four records. A record whose length byte holds L takes L+3 bytes in all: the length byte, L text bytes and two trailing bytes. The next length byte, or for the fourth record the first searched byte, follows at once, and no record byte is ever forwarded.
- R4: In raw mode (mode_comp=0) the payload starts at the first of four back-to-back 0xFF bytes after the records, and those four 0xFF bytes are forwarded ahead of the rest.
- R5: In raw mode, runs of fewer than four 0xFF bytes that end in some other byte are dropped and are never output.
- R6: In compressed mode (mode_comp=1) the pattern is 0xFF followed by a byte whose upper nibble is 0x3. Neither byte is forwarded, and output begins with the next byte.
- R7: In compressed mode, 0xFF followed by a byte that is not 0x3x, and a 0x3x byte that does not follow 0xFF, are both dropped. The sequence 0xFF 0xFF 0x3x matches on its last two bytes.
- R8: While out_valid is 1 and out_ready is 0, in_ready is 0 and out_data is held.
- R9: out_last is 1 only on the output byte that carries the final input byte. After that handshake, in_ready and out_valid stay 0 until reset.
- R10: If in_last is accepted before a pattern match completes, no_sync_err rises and stays 1 until reset, and no byte is output.
- R11: payload_count goes up by one on each output handshake.
- R12: If in_last arrives on the byte that completes the pattern, no_sync_err stays 0. In raw mode the four 0xFF bytes are sent with out_last on the fourth. In compressed mode nothing is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_comp | input | 1 | 0 = raw pattern (kept), 1 = compressed pattern (dropped) |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Input byte is the final byte of the file |
| in_ready | output | 1 | Block accepts the input byte |
| out_valid | output | 1 | Payload byte valid |
| out_data | output | 8 | Payload byte |
| out_last | output | 1 | Final payload byte |
| out_ready | input | 1 | Downstream accepts the payload byte |
| payload_count | output | CNT_W | Payload bytes forwarded |
| no_sync_err | output | 1 | Input ended before a pattern match |

## Verification
The end-of-input flag can land on the same byte that completes the pattern. The block then has to resolve a match and a possible error in one cycle. The bench builds files that end exactly on the fourth 0xFF in raw mode and on the 0x3x byte in compressed mode. It requires no error, four 0xFF bytes with the last flag on the fourth in raw mode, and no output in compressed mode. It also builds files that end one byte short of a match, and these must set the error and produce no output.

// File: rtl/bitstream_payload_locator.sv
module bitstream_payload_locator #(
  parameter int HDR_START = 15,
  parameter int NUM_REC   = 4,
  parameter int SYNC_RUN  = 4,
  parameter int CNT_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_comp,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  output logic             in_ready,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic             out_last,
  input  logic             out_ready,
  output logic [CNT_W-1:0] payload_count,
  output logic             no_sync_err
);
  localparam int HS_W  = $clog2(HDR_START + 1);
  localparam int SK_W  = (HS_W > 9) ? HS_W : 9;
  localparam int RC_W  = $clog2(NUM_REC + 1);
  localparam int RUN_W = $clog2(SYNC_RUN + 1);

  typedef enum logic [2:0] {S_HDR, S_SEEK, S_EMIT, S_PASS, S_FIN} st_t;

  st_t              st;
  logic [SK_W-1:0]  skip;
  logic [RC_W-1:0]  recs;
  logic [RUN_W-1:0] run;
  logic             prev_ff;
  logic             emit_last;

  wire take     = in_valid && in_ready;
  wire give     = out_valid && out_ready;
  wire is_ff    = (in_data == 8'hFF);
  wire raw_hit  = !mode_comp && is_ff && (run == RUN_W'(SYNC_RUN - 1));
  wire comp_hit = mode_comp && prev_ff && (in_data[7:4] == 4'h3);

  assign in_ready  = (st == S_HDR) || (st == S_SEEK) || ((st == S_PASS) && out_ready);
  assign out_valid = (st == S_EMIT) || ((st == S_PASS) && in_valid);
  assign out_data  = (st == S_EMIT) ? 8'hFF : in_data;
  assign out_last  = (st == S_EMIT) ? (emit_last && (run == RUN_W'(1)))
                                    : ((st == S_PASS) && in_last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st            <= S_HDR;
      skip          <= SK_W'(HDR_START);
      recs          <= '0;
      run           <= '0;
      prev_ff       <= 1'b0;
      emit_last     <= 1'b0;
      payload_count <= '0;
      no_sync_err   <= 1'b0;
    end else begin
      if (give) payload_count <= payload_count + 1'b1;
      case (st)
        S_HDR: if (take) begin
          if (skip == '0) begin
            skip <= SK_W'(in_data) + SK_W'(2);
            recs <= recs + 1'b1;
          end else if (skip == SK_W'(1) && recs == RC_W'(NUM_REC)) begin
            st <= S_SEEK;
          end else begin
            skip <= skip - 1'b1;
          end
          if (in_last) begin
            st          <= S_FIN;
            no_sync_err <= 1'b1;
          end
        end
        S_SEEK: if (take) begin
          prev_ff <= is_ff;
          run     <= is_ff ? run + 1'b1 : '0;
          if (raw_hit) begin
            st        <= S_EMIT;
            run       <= RUN_W'(SYNC_RUN);
            emit_last <= in_last;
          end else if (comp_hit) begin
            st <= in_last ? S_FIN : S_PASS;
          end else if (in_last) begin
            st          <= S_FIN;
            no_sync_err <= 1'b1;
          end
        end
        S_EMIT: if (give) begin
          run <= run - 1'b1;
          if (run == RUN_W'(1)) st <= emit_last ? S_FIN : S_PASS;
        end
        S_PASS: if (give && in_last) st <= S_FIN;
        S_FIN: ;
        default: st <= S_FIN;
      endcase
    end
  end

  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    no_sync_err |=> no_sync_err); // R10
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    no_sync_err |-> !out_valid); // R10
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(no_sync_err) |-> $past(in_valid && in_ready && in_last)); // R10
  AST_STALL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R8
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R8
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (payload_count == CNT_W'($past(payload_count) + 1'b1))); // R11
  AST_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> (!in_ready && !out_valid)); // R9
endmodule

// File: tb/sim_bitstream_payload_locator.sv
module sim_bitstream_payload_locator;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, mode_comp, in_valid, in_last, in_ready, out_valid, out_last, out_ready;
  logic [7:0] in_data, out_data;
  logic [15:0] payload_count;
  logic no_sync_err;

  bitstream_payload_locator u0 (
    .clk(clk), .rst_n(rst_n), .mode_comp(mode_comp),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last), .out_ready(out_ready),
    .payload_count(payload_count), .no_sync_err(no_sync_err)
  );

  int checks = 0;
  int errors = 0;
  int cyc_total = 0;
  logic [7:0] stim [0:2047];
  int n;
  logic [7:0] expq[$];
  logic [7:0] got[$];
  int got_last;
  int bp_viol;

  task automatic chk(bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc_total++;
    if (cyc_total > 190000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc_total, 190000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic put(logic [7:0] b);
    stim[n] = b;
    n++;
  endtask

  task automatic do_reset(bit m);
    rst_n = 1'b0; mode_comp = m; in_valid = 1'b0; in_last = 1'b0;
    in_data = 8'h00; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    n = 0;
    expq.delete();
    got.delete();
    got_last = -1;
    bp_viol = 0;
  endtask

  function automatic int lenf(int v, int r);
    case (v)
      0: return 0;
      1: return (r * 53 + 7) % 256;
      2: return 255;
      default: return r + 1;
    endcase
  endfunction

  task automatic build_header(int v);
    for (int i = 0; i < 15; i++) put((i % 3 == 0) ? 8'hFF : 8'h3A);
    for (int r = 0; r < 4; r++) begin
      put(8'(lenf(v, r)));
      for (int t = 0; t < lenf(v, r); t++) put(t[0] ? 8'hFF : 8'h31);
      put(8'h0D);
      put(8'h0A);
    end
  endtask

  task automatic run_stream(int seed);
    int idx = 0;
    int tail = 0;
    int cyc = 0;
    while (!(idx >= n && tail >= 10)) begin
      @(negedge clk);
      out_ready = (seed == 0) ? 1'b1 : (((cyc * seed) % 5) != 2);
      in_valid  = (idx < n);
      in_data   = (idx < n) ? stim[idx] : 8'h00;
      in_last   = (idx == n - 1);
      #1;
      if (out_valid && !out_ready && in_ready) bp_viol++;
      if (out_valid && out_ready) begin
        got.push_back(out_data);
        if (out_last) got_last = got.size() - 1;
      end
      if (in_valid && in_ready) idx++;
      if (idx >= n) tail++;
      cyc++;
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last = 1'b0;
    #1;
  endtask

  task automatic verify(string tag, bit exp_err);
    int mism = 0;
    chk(got.size() == expq.size(), {tag, " output length"}, got.size(), expq.size());
    foreach (expq[i]) if (i >= got.size() || got[i] !== expq[i]) mism++;
    chk(mism == 0, {tag, " byte mismatches"}, mism, 0);
    chk(got_last == expq.size() - 1, {tag, " R9 last position"}, got_last, expq.size() - 1);
    chk(int'(payload_count) == expq.size(), {tag, " R11 payload_count"}, payload_count, expq.size());
    chk(no_sync_err == exp_err, {tag, " R10 no_sync_err"}, no_sync_err, exp_err);
    chk(in_ready == 1'b0 && out_valid == 1'b0, {tag, " R9 idle after end"}, in_ready, 0);
    chk(bp_viol == 0, {tag, " R8 in_ready under stall"}, bp_viol, 0);
  endtask

  initial begin
    do_reset(1'b0);
    #1;
    chk(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);
    chk(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    chk(payload_count == 16'd0, "R1 payload_count after reset", payload_count, 0);
    chk(no_sync_err == 1'b0, "R1 no_sync_err after reset", no_sync_err, 0);

    for (int m = 0; m < 2; m++)
      for (int v = 0; v < 4; v++)
        for (int pi = 0; pi < 3; pi++) begin
          int plen = (pi == 0) ? 1 : (pi == 1) ? 3 : 17;
          do_reset(m[0]);
          build_header(v);
          if (m == 0) begin
            put(8'hFF); put(8'hFF); put(8'hFF); put(8'h00); put(8'h12);
            for (int k = 0; k < 4; k++) begin put(8'hFF); expq.push_back(8'hFF); end
          end else begin
            put(8'hFF); put(8'h20); put(8'h35); put(8'hFF); put(8'h41);
            put(8'hFF); put(8'hFF); put(8'(8'h30 + v));
          end
          for (int i = 0; i < plen; i++) begin
            logic [7:0] b = 8'((i * 37 + v * 11 + 5) & 255);
            put(b);
            expq.push_back(b);
          end
          run_stream((v + plen) % 2 == 1 ? 3 : 0);
          verify(m == 0 ? "R2 R3 R4 R5 raw sweep" : "R2 R3 R6 R7 compressed sweep", 1'b0);
        end

    do_reset(1'b0);
    build_header(3);
    n = 20;
    run_stream(0);
    verify("R10 end inside header", 1'b1);

    do_reset(1'b0);
    build_header(1);
    put(8'hFF); put(8'hFF); put(8'hFF);
    run_stream(3);
    verify("R10 raw end one byte short", 1'b1);

    do_reset(1'b1);
    build_header(1);
    put(8'h33); put(8'hFF); put(8'h20); put(8'hFF);
    run_stream(0);
    verify("R10 compressed end one byte short", 1'b1);

    do_reset(1'b0);
    build_header(2);
    for (int k = 0; k < 4; k++) begin put(8'hFF); expq.push_back(8'hFF); end
    run_stream(3);
    verify("R12 raw end on sync", 1'b0);

    do_reset(1'b1);
    build_header(2);
    put(8'hFF); put(8'h3F);
    run_stream(0);
    verify("R12 compressed end on sync", 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule